// File: doc/BRIEF.md
# Flash Command Sequencer with Error Status

This block sits between a processor's write port and the control side of an on-chip flash array. Software issues commands as one or two bus writes. The first write carries a command byte. The second write carries either the data and address of a program, or a confirm byte for an erase or lock operation. The sequencer keeps one lock flag per block and checks the target block against it. It then hands accepted operations to an array back end through a level request that is held until the back end pulses done together with a pass or fail flag.

Software reads the result from a ready flag and a two-bit error code. The code tells apart three cases: a malformed sequence, a failed or refused erase, and a failed or refused program. A global override input makes every block count as unlocked. The "erase all unlocked" command steps through the blocks and sends one per-block erase to the back end for each block that is eligible. A read-array flag shows when the controller has been put back into plain read mode.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `ready`=1, `err_code`=00, `rd_array`=1, `lock_state`=0 and `be_req`=0.
- R2: `err_code` encodings: 11 = command sequence error, 10 = erase error, 01 = program error, 00 = none. A first-cycle write of 50h (clear status) returns it to 00.
- R3: For first-cycle codes 20h (block erase), A7h (erase all unlocked) and 77h (lock program), the second write must carry D0h in bits [7:0]. Any other byte except FFh sets code 11 and starts no back-end operation.
- R4: FFh in bits [7:0] of that second write drops the pending command with no error, starts no operation and sets `rd_array`=1. A first-cycle FFh also sets `rd_array`=1. Any accepted two-cycle first write clears `rd_array`.
- R5: When the override is clear, a block erase on a locked block sets code 10 and a program (40h, then data write) on a locked block sets code 01. In both cases no back-end operation starts. The block index is address bits [7:6].
- R6: A back-end fail on an erase sets code 10. A back-end fail on a program or lock program sets code 01.
- R7: With `lock_override`=1, locked blocks are treated as unlocked and no lock error is raised.
- R8: The error code is sticky until 50h is written. While it is non-zero, a first write of 40h, 20h, A7h or 77h is refused, sets code 11 and starts nothing. Writing FFh does not clear the error.
- R9: `ready` is 0 from the edge that accepts the second write until the back end signals done. Writes while `ready`=0 are ignored.
- R10: Erase all unlocked issues one erase per eligible block in ascending order and skips locked blocks silently. It stops with code 10 at the first block whose back-end erase fails.
- R11: A passing lock program sets that block's `lock_state` bit. A passing erase clears it.
- R12: Operations reach the back end with `be_op` 00 = program, 01 = erase, 10 = lock program, plus the target block. A program also carries the second write's address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | 8 | Bus write address; bits [7:6] select the block |
| wr_data | input | 16 | Bus write data; command bytes in bits [7:0] |
| lock_override | input | 1 | 1 = ignore all lock flags |
| ready | output | 1 | 1 = idle or awaiting second write |
| err_code | output | 2 | Sticky error code |
| rd_array | output | 1 | 1 = controller in read-array mode |
| lock_state | output | 4 | Per-block lock flags, 1 = locked |
| be_req | output | 1 | Back-end request, held until done |
| be_op | output | 2 | Back-end operation code |
| be_blk | output | 2 | Target block |
| be_addr | output | 8 | Target address |
| be_data | output | 16 | Program data |
| be_done | input | 1 | One-cycle completion pulse from back end |
| be_pass | input | 1 | Result qualifier valid with be_done |

## Verification
The assertions assume that the back end pulses `be_done` for a single cycle and only while `be_req` is high. They also assume that `lock_override` does not change while an operation is in flight. The bench's back-end model answers a fixed three cycles after it sees the request and drops `done` after one cycle. The bench changes `lock_override` only while `ready` is high. The sweeps cover every lock pattern, every block, both override settings, every second-cycle byte and every single-block failure point of erase-all.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [1:0] {
    ERR_NONE  = 2'b00,
    ERR_PROG  = 2'b01,
    ERR_ERASE = 2'b10,
    ERR_SEQ   = 2'b11
  } err_t;

  typedef enum logic [1:0] {
    BE_PROG  = 2'b00,
    BE_ERASE = 2'b01,
    BE_LOCK  = 2'b10
  } beop_t;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_PROG, CMD_BERASE, CMD_ALL, CMD_LOCK, CMD_CLR, CMD_RDARR
  } cmd_t;

  typedef enum logic [1:0] {
    ST_IDLE, ST_CYC2, ST_RUN, ST_SCAN
  } st_t;

  localparam logic [7:0] C_PROG    = 8'h40;
  localparam logic [7:0] C_BERASE  = 8'h20;
  localparam logic [7:0] C_ALL     = 8'hA7;
  localparam logic [7:0] C_LOCK    = 8'h77;
  localparam logic [7:0] C_CLR     = 8'h50;
  localparam logic [7:0] C_RDARR   = 8'hFF;
  localparam logic [7:0] C_CONFIRM = 8'hD0;
endpackage

// File: rtl/fcs_decode.sv
module fcs_decode
  import fcs_pkg::*;
(
  input  logic [7:0] code_byte,
  output cmd_t       cmd,
  output logic       confirm,
  output logic       abort
);
  always_comb begin
    unique case (code_byte)
      C_PROG:   cmd = CMD_PROG;
      C_BERASE: cmd = CMD_BERASE;
      C_ALL:    cmd = CMD_ALL;
      C_LOCK:   cmd = CMD_LOCK;
      C_CLR:    cmd = CMD_CLR;
      C_RDARR:  cmd = CMD_RDARR;
      default:  cmd = CMD_NONE;
    endcase
  end

  assign confirm = (code_byte == C_CONFIRM);
  assign abort   = (code_byte == C_RDARR);
endmodule

// File: rtl/fcs_lockbank.sv
module fcs_lockbank #(
  parameter int BLK_BITS = 2,
  localparam int NBLK    = 1 << BLK_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic                clr_en,
  input  logic [BLK_BITS-1:0] upd_blk,
  input  logic [BLK_BITS-1:0] q_blk,
  input  logic                override,
  output logic                q_eff_locked,
  output logic [NBLK-1:0]     lock_vec
);
  logic [NBLK-1:0] lock_q, lock_n;

  always_comb begin
    lock_n = lock_q;
    if (set_en) lock_n[upd_blk] = 1'b1;
    else if (clr_en) lock_n[upd_blk] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= '0;
    else if (set_en || clr_en) lock_q <= lock_n;
  end

  assign q_eff_locked = lock_q[q_blk] && !override;
  assign lock_vec     = lock_q;

  // R11: a passing lock program leaves the target block locked
  a_r11_lock_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> lock_vec[$past(upd_blk)]);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int BLK_BITS = 2,
  localparam int NBLK    = 1 << BLK_BITS,
  localparam int OFF_W   = ADDR_W - BLK_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                lock_override,
  output logic                ready,
  output logic [1:0]          err_code,
  output logic                rd_array,
  output logic [NBLK-1:0]     lock_state,
  output logic                be_req,
  output logic [1:0]          be_op,
  output logic [BLK_BITS-1:0] be_blk,
  output logic [ADDR_W-1:0]   be_addr,
  output logic [DATA_W-1:0]   be_data,
  input  logic                be_done,
  input  logic                be_pass
);
  st_t                 st_q, st_n;
  cmd_t                cmd_q, cmd_n;
  beop_t               op_q, op_n;
  err_t                err_q, err_n;
  logic [BLK_BITS-1:0] blk_q, blk_n;
  logic [ADDR_W-1:0]   addr_q, addr_n;
  logic [DATA_W-1:0]   data_q, data_n;
  logic [BLK_BITS:0]   idx_q, idx_n;
  logic                all_q, all_n, rdarr_q, rdarr_n;

  cmd_t                dec_cmd;
  logic                dec_confirm, dec_abort;
  logic [BLK_BITS-1:0] wr_blk, q_blk;
  logic                eff_locked, lk_set, lk_clr, run_ok;

  fcs_decode u_dec (
    .code_byte (wr_data[7:0]),
    .cmd       (dec_cmd),
    .confirm   (dec_confirm),
    .abort     (dec_abort)
  );

  assign wr_blk = wr_addr[ADDR_W-1 -: BLK_BITS];
  assign q_blk  = (st_q == ST_SCAN) ? idx_q[BLK_BITS-1:0] : wr_blk;
  assign run_ok = (st_q == ST_RUN) && be_done && be_pass;
  assign lk_set = run_ok && (op_q == BE_LOCK);
  assign lk_clr = run_ok && (op_q == BE_ERASE);

  fcs_lockbank #(.BLK_BITS(BLK_BITS)) u_lock (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_en       (lk_set),
    .clr_en       (lk_clr),
    .upd_blk      (blk_q),
    .q_blk        (q_blk),
    .override     (lock_override),
    .q_eff_locked (eff_locked),
    .lock_vec     (lock_state)
  );

  always_comb begin
    st_n = st_q;  cmd_n = cmd_q;  op_n = op_q;  err_n = err_q;
    blk_n = blk_q;  addr_n = addr_q;  data_n = data_q;
    idx_n = idx_q;  all_n = all_q;  rdarr_n = rdarr_q;
    unique case (st_q)
      ST_IDLE: if (wr_en) begin
        unique case (dec_cmd)
          CMD_PROG, CMD_BERASE, CMD_ALL, CMD_LOCK:
            if (err_q != ERR_NONE) err_n = ERR_SEQ;
            else begin
              st_n = ST_CYC2;  cmd_n = dec_cmd;  rdarr_n = 1'b0;
            end
          CMD_CLR:   err_n = ERR_NONE;
          CMD_RDARR: rdarr_n = 1'b1;
          default: ;
        endcase
      end
      ST_CYC2: if (wr_en) begin
        st_n   = ST_IDLE;
        blk_n  = wr_blk;
        addr_n = wr_addr;
        data_n = wr_data;
        if (cmd_q == CMD_PROG) begin
          if (eff_locked) err_n = ERR_PROG;
          else begin op_n = BE_PROG; st_n = ST_RUN; end
        end else if (dec_abort) begin
          rdarr_n = 1'b1;
        end else if (!dec_confirm) begin
          err_n = ERR_SEQ;
        end else begin
          unique case (cmd_q)
            CMD_BERASE:
              if (eff_locked) err_n = ERR_ERASE;
              else begin op_n = BE_ERASE; st_n = ST_RUN; end
            CMD_LOCK: begin op_n = BE_LOCK; st_n = ST_RUN; end
            CMD_ALL:  begin all_n = 1'b1; idx_n = '0; st_n = ST_SCAN; end
            default: ;
          endcase
        end
      end
      ST_RUN: if (be_done) begin
        if (!be_pass) begin
          err_n = (op_q == BE_ERASE) ? ERR_ERASE : ERR_PROG;
          st_n  = ST_IDLE;
          all_n = 1'b0;
        end else if (all_q) begin
          idx_n = idx_q + 1'b1;
          st_n  = ST_SCAN;
        end else begin
          st_n = ST_IDLE;
        end
      end
      ST_SCAN: begin
        if (idx_q == (BLK_BITS+1)'(NBLK)) begin
          st_n = ST_IDLE;  all_n = 1'b0;
        end else if (eff_locked) begin
          idx_n = idx_q + 1'b1;
        end else begin
          op_n   = BE_ERASE;
          blk_n  = idx_q[BLK_BITS-1:0];
          addr_n = {idx_q[BLK_BITS-1:0], {OFF_W{1'b0}}};
          st_n   = ST_RUN;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  cmd_q <= CMD_NONE;  op_q <= BE_PROG;  err_q <= ERR_NONE;
      blk_q <= '0;  addr_q <= '0;  data_q <= '0;  idx_q <= '0;
      all_q <= 1'b0;  rdarr_q <= 1'b1;
    end else begin
      st_q <= st_n;  cmd_q <= cmd_n;  op_q <= op_n;  err_q <= err_n;
      blk_q <= blk_n;  addr_q <= addr_n;  data_q <= data_n;  idx_q <= idx_n;
      all_q <= all_n;  rdarr_q <= rdarr_n;
    end
  end

  assign ready    = (st_q == ST_IDLE) || (st_q == ST_CYC2);
  assign err_code = err_q;
  assign rd_array = rdarr_q;
  assign be_req   = (st_q == ST_RUN);
  assign be_op    = op_q;
  assign be_blk   = blk_q;
  assign be_addr  = addr_q;
  assign be_data  = data_q;

  // R9: software never sees ready while the back end is working
  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    be_req |-> !ready);

  // R9: request and target held until done
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (be_req && !be_done) |=> (be_req && $stable(be_blk) && $stable(be_op)));

  // R8: a pending error survives anything but a clear status write
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != 2'b00 && !(ready && wr_en && dec_cmd == CMD_CLR)) |=> (err_code != 2'b00));

  // R5 R7: no program or erase is launched on an effectively locked block
  a_r5_no_locked_launch: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(be_req) && be_op != BE_LOCK) |-> (lock_override || !lock_state[be_blk]));

  // R11: a passing erase leaves its block unlocked
  a_r11_erase_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (be_req && be_done && be_pass && be_op == 2'b01) |=> !lock_state[$past(be_blk)]);
endmodule

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        lock_override = 1'b0;
  logic        ready, rd_array, be_req;
  logic [1:0]  err_code, be_op, be_blk;
  logic [3:0]  lock_state;
  logic [7:0]  be_addr;
  logic [15:0] be_data;
  logic        be_done = 1'b0, be_pass = 1'b0;

  int checks = 0, fails = 0, cyc = 0;

  // back-end model state
  logic [3:0]  fail_mask = '0;
  logic        mclr = 1'b0;
  int          req_cnt = 0;
  logic [3:0]  erased = '0;
  logic [1:0]  last_op = '0;
  logic [7:0]  last_addr = '0;
  logic [15:0] last_data = '0;
  int          lat = 0;

  always #2 clk = ~clk;

  flash_cmd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lock_override(lock_override), .ready(ready), .err_code(err_code),
    .rd_array(rd_array), .lock_state(lock_state), .be_req(be_req), .be_op(be_op),
    .be_blk(be_blk), .be_addr(be_addr), .be_data(be_data),
    .be_done(be_done), .be_pass(be_pass)
  );

  always @(posedge clk) begin
    be_done <= 1'b0;
    if (mclr) begin
      req_cnt <= 0; erased <= '0; lat <= 0;
    end else if (be_req && !be_done) begin
      if (lat == 2) begin
        lat       <= 0;
        be_done   <= 1'b1;
        be_pass   <= !fail_mask[be_blk];
        req_cnt   <= req_cnt + 1;
        last_op   <= be_op;
        last_addr <= be_addr;
        last_data <= be_data;
        if (be_op == 2'b01 && !fail_mask[be_blk]) erased[be_blk] <= 1'b1;
      end else lat <= lat + 1;
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      summary();
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 200; i++) begin
      if (ready) break;
      @(negedge clk);
    end
  endtask

  task automatic clear_model();
    @(negedge clk); mclr = 1'b1;
    @(negedge clk); mclr = 1'b0;
  endtask

  task automatic set_locks(input logic [3:0] pat);
    fail_mask = '0;
    wr(8'h00, 16'h0050);
    lock_override = 1'b1;
    wr(8'h00, 16'h00A7); wr(8'h00, 16'h00D0); wait_ready();
    lock_override = 1'b0;
    for (int b = 0; b < 4; b++)
      if (pat[b]) begin
        wr(8'(b << 6), 16'h0077); wr(8'(b << 6), 16'h00D0); wait_ready();
      end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", ready, 1);
    chk("R1 err", err_code, 0);
    chk("R1 rd_array", rd_array, 1);
    chk("R1 locks", lock_state, 0);
    chk("R1 be_req", be_req, 0);

    // Sweep A: program and block erase against every lock pattern/override/block
    for (int pat = 0; pat < 16; pat++)
      for (int ld = 0; ld < 2; ld++)
        for (int b = 0; b < 4; b++)
          for (int er = 0; er < 2; er++) begin
            logic lk;
            logic [7:0] a;
            logic [3:0] exp_locks;
            set_locks(4'(pat));
            chk("R11 lock program pattern", lock_state, pat);
            lock_override = ld[0];
            clear_model();
            lk = pat[b] && (ld == 0);
            a = 8'((b << 6) | (pat * 3 + b));
            if (er == 1) begin
              wr(a, 16'h0020); wr(a, 16'h00D0);
            end else begin
              wr(a, 16'h0040); wr(a, 16'(16'hA500 + pat * 8 + b));
            end
            chk("R9 ready after accept", ready, lk ? 1 : 0);
            wait_ready();
            @(negedge clk);
            chk(lk ? (er ? "R5 erase locked" : "R5 program locked") : "R7 unlocked op",
                err_code, lk ? (er ? 2 : 1) : 0);
            chk("R5 R7 request count", req_cnt, lk ? 0 : 1);
            exp_locks = 4'(pat);
            if (er == 1 && !lk) exp_locks[b] = 1'b0;
            chk("R11 locks after op", lock_state, exp_locks);
            if (!lk) begin
              chk("R12 op code", last_op, er ? 1 : 0);
              chk("R12 address", last_addr, a);
              if (er == 0) chk("R12 data", last_data, 16'hA500 + pat * 8 + b);
            end
            lock_override = 1'b0;
          end

    // Sweep B: every second-cycle byte for the three confirmed commands
    set_locks(4'b0000);
    for (int c = 0; c < 3; c++)
      for (int v = 0; v < 256; v++) begin
        logic [7:0] code;
        int exp_err, exp_req;
        code = (c == 0) ? 8'h20 : (c == 1) ? 8'h77 : 8'hA7;
        wr(8'h00, 16'h0050);
        clear_model();
        wr(8'h40, {8'h00, code});
        chk("R4 rd_array cleared by first write", rd_array, 0);
        wr(8'h40, {8'h3C, 8'(v)});
        wait_ready();
        @(negedge clk);
        exp_err = (v == 8'hD0 || v == 8'hFF) ? 0 : 3;
        exp_req = (v != 8'hD0) ? 0 : (c == 2) ? 4 : 1;
        chk("R3 second-cycle error", err_code, exp_err);
        chk("R3 R4 request count", req_cnt, exp_req);
        if (v == 8'hFF) chk("R4 abort to read array", rd_array, 1);
        if (c == 1 && v == 8'hD0) begin
          set_locks(4'b0000);
        end
      end

    // Sweep C: erase-all over lock patterns, override, failing block
    for (int pat = 0; pat < 16; pat++)
      for (int ld = 0; ld < 2; ld++)
        for (int fb = -1; fb < 4; fb++) begin
          int exp_req; logic failed; logic [3:0] exp_locks;
          set_locks(4'(pat));
          lock_override = ld[0];
          fail_mask = (fb < 0) ? 4'b0 : 4'(1 << fb);
          clear_model();
          wr(8'h00, 16'h00A7); wr(8'h00, 16'h00D0);
          chk("R9 busy during erase all", ready, 0);
          wait_ready();
          @(negedge clk);
          exp_req = 0; failed = 1'b0; exp_locks = 4'(pat);
          for (int b = 0; b < 4; b++)
            if (!failed && (!pat[b] || ld == 1)) begin
              exp_req++;
              if (b == fb) failed = 1'b1;
              else exp_locks[b] = 1'b0;
            end
          chk("R10 erase-all requests", req_cnt, exp_req);
          chk("R10 R6 erase-all error", err_code, failed ? 2 : 0);
          chk("R10 R11 locks after erase-all", lock_state, exp_locks);
          lock_override = 1'b0;
          fail_mask = '0;
        end

    // R6 program and lock program failures
    set_locks(4'b0000);
    fail_mask = 4'b1111;
    wr(8'h80, 16'h0040); wr(8'h81, 16'h1234); wait_ready(); @(negedge clk);
    chk("R6 program fail", err_code, 1);
    wr(8'h00, 16'h0050);
    chk("R2 clear status", err_code, 0);
    wr(8'h80, 16'h0077); wr(8'h80, 16'h00D0); wait_ready(); @(negedge clk);
    chk("R6 lock program fail", err_code, 1);
    chk("R6 lock not set on fail", lock_state, 0);
    fail_mask = '0;

    // R8 sticky error and refusal
    clear_model();
    wr(8'h00, 16'h00FF);
    chk("R8 FF keeps error", err_code, 1);
    chk("R4 first-cycle FF read array", rd_array, 1);
    wr(8'h00, 16'h0040);
    chk("R8 refused with sequence error", err_code, 3);
    chk("R8 no pending second cycle", ready, 1);
    wr(8'h00, 16'h1234);
    @(negedge clk);
    chk("R8 no request", req_cnt, 0);
    wr(8'h00, 16'h0050);
    chk("R2 clear after sequence error", err_code, 0);

    // R9 writes while busy ignored
    clear_model();
    wr(8'h40, 16'h0020); wr(8'h40, 16'h00D0);
    wr(8'h00, 16'h00FF);
    wr(8'h00, 16'h0077);
    wait_ready(); @(negedge clk);
    chk("R9 busy FF ignored", rd_array, 0);
    chk("R9 busy write no second command", ready, 1);
    wr(8'h00, 16'h00D0);
    @(negedge clk);
    chk("R9 busy command not pending", err_code, 0);
    chk("R9 single request", req_cnt, 1);

    summary();
  end
endmodule